// File: doc/BRIEF.md
# Periodic Rate and Square-Wave Timer Core

This block is the counting element of one 16-bit interval-timer channel when that channel runs in one of its two periodic modes. In rate mode it divides the count-tick stream by N and emits one low tick per period. In square-wave mode it produces an output that is high for the first half of every N ticks and low for the second half. Counting can run in straight binary or in four packed decimal digits.

The block runs on a system clock. A separate `tick` enable marks the clock edges on which the count advances. Host bus decoding sits outside the block and reaches it through two strobes. The first is a configuration strobe that selects the mode and number format and leaves the channel idle. The second is a count strobe that delivers a new initial count. The `gate` input has two roles. Its level pauses counting and forces the output high. Its rising edge restarts the current period from the stored initial count, which lets external hardware align the waveform.

A count written while the channel is running does not disturb the waveform in progress. The channel picks up the new value at its next natural reload, or earlier if a gate trigger arrives first.

Top module: `ptmr_periodic`

## Requirements
- R1: After reset, `out` is 1, `count` is 0, the mode is rate, the format is binary, and the channel is idle.
- R2: A `cfg_wr` strobe (`cfg_mode` 0 = rate, 1 = square; `cfg_bcd` 1 = packed decimal) sets `out` to 1 at the next clock and idles the channel. While idle, `count` does not move on ticks. After a following `cnt_wr`, the count loads on the next tick.
- R3: Rate mode. `count` steps down by one per tick. When `count` becomes 1, `out` is 0 for exactly that one tick. The next tick reloads the initial count and raises `out`, so the period is N ticks.
- R4: Square mode, even N. `count` steps down by two per tick. When it would reach zero it reloads N and `out` toggles, giving N/2 ticks high and N/2 ticks low.
- R5: Square mode, odd N. In the high phase, the step after a reload is one and later steps are two. In the low phase, the first step is three and later steps are two. `out` is high for (N+1)/2 ticks and low for (N-1)/2 ticks.
- R6: While `gate` is 0, counting halts, and at the next clock `out` is 1 whether or not `tick` is set.
- R7: A rising edge on `gate` makes the next tick reload the initial count, even if that tick arrives several clocks after the edge. The remembered edge is cleared by that tick.
- R8: A `cnt_wr` while the channel is running leaves the current period (rate) or half-cycle (square) unchanged. The new value is used at the next reload.
- R9: An initial count of 0 acts as 65536 in binary and as 10000 in decimal. In square mode this gives half-periods of 32768 and 5000 ticks.
- R10: In decimal format, each nibble of `count` is one digit with bits 15:12 as the most significant. Steps of one, two and three borrow across digits, for example 1000 becomes 0999, 0011 becomes 0008 in the low phase, and 0000 becomes 9999.
- R11: With `tick` at 0, `count` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-advance enable, one clock wide per tick |
| gate | input | 1 | Level enables counting; rising edge retriggers |
| cfg_wr | input | 1 | Configuration strobe |
| cfg_mode | input | 1 | 0 = rate generator, 1 = square wave |
| cfg_bcd | input | 1 | 1 = packed decimal counting |
| cnt_wr | input | 1 | Initial-count strobe |
| cnt_val | input | 16 | Initial count value |
| out | output | 1 | Timer output |
| count | output | 16 | Live count |

## Verification
The hardest situation to reach is a count written mid-cycle and then overtaken by a gate trigger. The bench has to stop the gate while the old period is still running, then raise it again. The first loaded value after the edge must be the new count, not the old one. The stimulus chooses the new count so that it differs from the held count, which makes the two outcomes distinguishable at the ports.

The same test pattern also separates the edge from the tick. The gate edge is placed on clocks where `tick` is low, so the remembered trigger must survive idle clocks. The zero-means-full-range periods are measured by counting samples of `out` in each phase.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic {
    PM_RATE   = 1'b0,
    PM_SQUARE = 1'b1
  } pmode_e;

  // Decrement amounts handed to the step unit
  localparam logic [1:0] STEP_ONE   = 2'd1;
  localparam logic [1:0] STEP_TWO   = 2'd2;
  localparam logic [1:0] STEP_THREE = 2'd3;
endpackage

// File: rtl/ptmr_rst_sync.sv
module ptmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ptmr_gate_sync.sv
module ptmr_gate_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic gate,
  output logic gate_lvl,
  output logic trig
);
  logic gate_q;
  logic pend_q, pend_n;
  logic rise;

  // The edge is detected against the previous clock's level
  assign rise = gate & ~gate_q;

  // A remembered edge lives until a tick consumes it
  always_comb begin
    pend_n = pend_q;
    if (tick)      pend_n = 1'b0;
    else if (rise) pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      gate_q <= gate;
      pend_q <= pend_n;
    end
  end

  assign gate_lvl = gate;
  assign trig     = rise | pend_q;
endmodule

// File: rtl/ptmr_step.sv
module ptmr_step #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] val,
  input  logic [1:0]       amount,
  input  logic             bcd,
  output logic [CNT_W-1:0] res
);
  localparam int NDIG = CNT_W / 4;

  logic [CNT_W-1:0] res_bin;
  logic [CNT_W-1:0] res_dec;
  logic [NDIG-2:0]  borrow;

  assign res_bin = val - CNT_W'(amount);

  // One digit slice per decade, borrow rippling upward
  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [4:0] dig;
    logic [4:0] sub;
    logic       lt;
    logic [4:0] diff;

    assign dig = {1'b0, val[4*g +: 4]};
    if (g == 0) begin : g_lsd
      assign sub = {3'b000, amount};
    end else begin : g_upper
      assign sub = {4'b0000, borrow[g-1]};
    end
    assign lt   = (dig < sub);
    assign diff = lt ? (dig + 5'd10 - sub) : (dig - sub);
    assign res_dec[4*g +: 4] = diff[3:0];
    if (g < NDIG - 1) begin : g_bout
      assign borrow[g] = lt;
    end
  end

  assign res = bcd ? res_dec : res_bin;
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate_lvl,
  input  logic             trig,
  input  logic             cfg_wr,
  input  logic             cfg_mode,
  input  logic             cfg_bcd,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] step_res,
  output logic [1:0]       step_amt,
  output logic             step_bcd,
  output logic             out,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TWO   = CNT_W'(2);
  localparam logic [CNT_W-1:0] CNT_THREE = CNT_W'(3);

  pmode_e           mode_q, mode_n;
  logic             bcd_q, bcd_n;
  logic [CNT_W-1:0] init_q, init_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             out_q, out_n;
  logic             run_q, run_n;
  logic             ldreq_q, ldreq_n;

  logic cnt_odd;
  logic sq_expire;
  logic rate_last;
  logic do_load;
  logic advance;

  // Odd parity is the low bit in both number formats
  assign cnt_odd   = cnt_q[0];
  assign sq_expire = (cnt_q == CNT_TWO) || (!out_q && (cnt_q == CNT_THREE));
  assign rate_last = (cnt_q == CNT_ONE);
  assign do_load   = ldreq_q || (run_q && gate_lvl && trig);
  assign advance   = run_q && gate_lvl;

  always_comb begin
    if (mode_q == PM_RATE)  step_amt = STEP_ONE;
    else if (!cnt_odd)      step_amt = STEP_TWO;
    else if (out_q)         step_amt = STEP_ONE;
    else                    step_amt = STEP_THREE;
  end

  assign step_bcd = bcd_q;

  always_comb begin
    mode_n  = mode_q;
    bcd_n   = bcd_q;
    init_n  = init_q;
    cnt_n   = cnt_q;
    out_n   = out_q;
    run_n   = run_q;
    ldreq_n = ldreq_q;

    if (cfg_wr) begin
      mode_n  = pmode_e'(cfg_mode);
      bcd_n   = cfg_bcd;
      out_n   = 1'b1;
      run_n   = 1'b0;
      ldreq_n = 1'b0;
    end else if (tick) begin
      if (do_load) begin
        cnt_n   = init_q;
        out_n   = 1'b1;
        run_n   = 1'b1;
        ldreq_n = 1'b0;
      end else if (advance) begin
        if (mode_q == PM_RATE) begin
          if (rate_last) begin
            cnt_n = init_q;
            out_n = 1'b1;
          end else begin
            cnt_n = step_res;
            out_n = (cnt_q != CNT_TWO);
          end
        end else begin
          if (sq_expire) begin
            cnt_n = init_q;
            out_n = ~out_q;
          end else begin
            cnt_n = step_res;
          end
        end
      end
    end

    // Low gate forces the output high without waiting for a tick
    if (!gate_lvl) out_n = 1'b1;

    if (cnt_wr) begin
      init_n = cnt_val;
      if (cfg_wr || !run_q) ldreq_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= PM_RATE;
      bcd_q   <= 1'b0;
      init_q  <= '0;
      cnt_q   <= '0;
      out_q   <= 1'b1;
      run_q   <= 1'b0;
      ldreq_q <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      bcd_q   <= bcd_n;
      init_q  <= init_n;
      cnt_q   <= cnt_n;
      out_q   <= out_n;
      run_q   <= run_n;
      ldreq_q <= ldreq_n;
    end
  end

  assign out   = out_q;
  assign count = cnt_q;
endmodule

// File: rtl/ptmr_periodic.sv
module ptmr_periodic #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate,
  input  logic             cfg_wr,
  input  logic             cfg_mode,
  input  logic             cfg_bcd,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             out,
  output logic [CNT_W-1:0] count
);
  logic             rst_n_int;
  logic             gate_lvl;
  logic             trig;
  logic [1:0]       step_amt;
  logic             step_bcd;
  logic [CNT_W-1:0] step_res;

  ptmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ptmr_gate_sync u_gate (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .tick     (tick),
    .gate     (gate),
    .gate_lvl (gate_lvl),
    .trig     (trig)
  );

  ptmr_step #(.CNT_W(CNT_W)) u_step (
    .val    (count),
    .amount (step_amt),
    .bcd    (step_bcd),
    .res    (step_res)
  );

  ptmr_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .tick     (tick),
    .gate_lvl (gate_lvl),
    .trig     (trig),
    .cfg_wr   (cfg_wr),
    .cfg_mode (cfg_mode),
    .cfg_bcd  (cfg_bcd),
    .cnt_wr   (cnt_wr),
    .cnt_val  (cnt_val),
    .step_res (step_res),
    .step_amt (step_amt),
    .step_bcd (step_bcd),
    .out      (out),
    .count    (count)
  );
endmodule

// File: rtl/ptmr_periodic_chk.sv
module ptmr_periodic_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             gate,
  input logic             cfg_wr,
  input logic             cfg_mode,
  input logic [CNT_W-1:0] count,
  input logic             out
);
  // Mode as seen at the ports, tracked independently of the core
  logic rate_mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rate_mode_q <= 1'b1;
    else if (cfg_wr) rate_mode_q <= !cfg_mode;
  end

  a_r6_gate_low_out_high: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> out);

  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  a_r2_cfg_raises_out: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> out);

  a_r3_rate_low_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_mode_q && !out && tick && gate) |=> out);
endmodule

bind ptmr_periodic ptmr_periodic_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .gate     (gate),
  .cfg_wr   (cfg_wr),
  .cfg_mode (cfg_mode),
  .count    (count),
  .out      (out)
);

// File: tb/ptmr_periodic_tb.sv
module ptmr_periodic_tb;
  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        gate;
  logic        cfg_wr;
  logic        cfg_mode;
  logic        cfg_bcd;
  logic        cnt_wr;
  logic [15:0] cnt_val;
  logic        out;
  logic [15:0] count;

  int n_chk = 0;
  int n_bad = 0;

  // Scoreboard queues: one entry per negedge sample
  logic        q_out[$];
  logic        q_usec[$];
  logic [15:0] q_cnt[$];
  string       q_tag[$];

  ptmr_periodic #(.CNT_W(16)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .gate     (gate),
    .cfg_wr   (cfg_wr),
    .cfg_mode (cfg_mode),
    .cfg_bcd  (cfg_bcd),
    .cnt_wr   (cnt_wr),
    .cnt_val  (cnt_val),
    .out      (out),
    .count    (count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic samp();
    @(negedge clk);
  endtask

  task automatic push(logic o, logic usec, logic [15:0] c, string tag);
    q_out.push_back(o);
    q_usec.push_back(usec);
    q_cnt.push_back(c);
    q_tag.push_back(tag);
  endtask

  task automatic drain();
    while (q_out.size() != 0) step();
  endtask

  task automatic prog(logic m, logic b);
    cfg_mode = m;
    cfg_bcd  = b;
    cfg_wr   = 1'b1;
    step();
    cfg_wr   = 1'b0;
  endtask

  task automatic wr_cnt(logic [15:0] v);
    cnt_val = v;
    cnt_wr  = 1'b1;
    step();
    cnt_wr  = 1'b0;
  endtask

  // Rate mode: out low only when count is 1, period n
  task automatic run_rate(int n, int periods);
    push(1'b1, 1'b0, 16'h0, "R2 pre-load");
    push(1'b1, 1'b0, 16'h0, "R2 pre-load");
    for (int k = 0; k < n * periods; k++) begin
      int p = k % n;
      push(p != n - 1, 1'b1, 16'(n - p), "R3 rate");
    end
    wr_cnt(16'(n));
    drain();
  endtask

  // Square mode: high for (n+1)/2 ticks, low for the rest
  task automatic run_sq(int n, int periods);
    string tg;
    tg = (n % 2 == 0) ? "R4 square even" : "R5 square odd";
    push(1'b1, 1'b0, 16'h0, "R2 pre-load");
    push(1'b1, 1'b0, 16'h0, "R2 pre-load");
    for (int k = 0; k < n * periods; k++) begin
      int p = k % n;
      push(p < (n + 1) / 2, (p == 0), 16'(n), tg);
    end
    wr_cnt(16'(n));
    drain();
  endtask

  task automatic measure_zero(logic b, int exp_half, string tag);
    int hi;
    int lo;
    prog(1'b1, b);
    wr_cnt(16'h0000);
    step();
    hi = 0;
    lo = 0;
    samp();
    while (out === 1'b1 && hi < 70000) begin
      hi++;
      samp();
    end
    while (out === 1'b0 && lo < 70000) begin
      lo++;
      samp();
    end
    chk({tag, " high phase"}, hi, exp_half);
    chk({tag, " low phase"}, lo, exp_half);
    step();
  endtask

  // Monitor: compare each queued expectation at the negedge
  always @(negedge clk) begin
    if (q_out.size() != 0) begin
      logic        eo;
      logic        eu;
      logic [15:0] ec;
      string       et;
      eo = q_out.pop_front();
      eu = q_usec.pop_front();
      ec = q_cnt.pop_front();
      et = q_tag.pop_front();
      chk({et, " out"}, out, eo);
      if (eu) chk({et, " count"}, count, ec);
    end
  end

  initial begin
    #(190000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    rst_n = 1'b0; tick = 1'b1; gate = 1'b1;
    cfg_wr = 1'b0; cfg_mode = 1'b0; cfg_bcd = 1'b0;
    cnt_wr = 1'b0; cnt_val = 16'h0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    samp();
    chk("R1 reset out", out, 1);
    chk("R1 reset count", count, 0);

    // R2: configured but no count: stays idle on ticks
    step();
    prog(1'b0, 1'b0);
    repeat (3) step();
    samp();
    chk("R2 idle out", out, 1);
    chk("R2 idle count", count, 0);
    step();

    prog(1'b0, 1'b0); run_rate(3, 2);
    prog(1'b0, 1'b0); run_rate(2, 3);
    prog(1'b1, 1'b0); run_sq(4, 2);
    prog(1'b1, 1'b0); run_sq(5, 2);
    prog(1'b1, 1'b0); run_sq(3, 2);
    prog(1'b1, 1'b0); run_sq(2, 3);

    // R8: rewrite mid-period, old period finishes
    prog(1'b0, 1'b0);
    push(1'b1, 1'b0, 16'h0, "R8 pre");
    push(1'b1, 1'b0, 16'h0, "R8 pre");
    for (int p = 0; p < 5; p++) push(p != 4, 1'b1, 16'(5 - p), "R8 old period");
    for (int k = 0; k < 6; k++) push((k % 3) != 2, 1'b1, 16'(3 - (k % 3)), "R8 new period");
    wr_cnt(16'd5);
    step(); step();
    wr_cnt(16'd3);
    drain();

    // R6/R7/R11: gate halts, forces high, edge retriggers
    prog(1'b0, 1'b0);
    wr_cnt(16'd4);
    step(); step(); step(); step();
    tick = 1'b0; gate = 1'b0;
    samp();
    chk("R3 low at count 1 out", out, 0);
    chk("R3 low at count 1 count", count, 1);
    step();
    samp();
    chk("R6 gate low forces out", out, 1);
    chk("R11 no tick count held", count, 1);
    tick = 1'b1;
    step(); step();
    samp();
    chk("R6 gate low halts count", count, 1);
    tick = 1'b0; gate = 1'b1;
    step(); step();
    tick = 1'b1;
    step();
    samp();
    chk("R7 trigger reload count", count, 4);
    chk("R7 trigger reload out", out, 1);
    step();
    samp();
    chk("R7 counting after trigger", count, 3);
    step();

    // R7/R8 square: new count overtaken by a trigger
    prog(1'b1, 1'b0);
    wr_cnt(16'd8);
    step(); step();
    wr_cnt(16'd6);
    gate = 1'b0;
    step();
    samp();
    chk("R8 old count kept until trigger", count, 4);
    gate = 1'b1;
    step();
    samp();
    chk("R7 square trigger loads new count", count, 6);
    chk("R7 square trigger out", out, 1);
    step(); step(); step();
    samp();
    chk("R4 half period of new count out", out, 0);
    chk("R4 half period of new count count", count, 6);
    step();

    // R10: decimal borrows
    prog(1'b0, 1'b1);
    wr_cnt(16'h1000);
    step();
    samp();
    chk("R10 decimal load", count, 16'h1000);
    step();
    samp();
    chk("R10 decimal 1000 minus 1", count, 16'h0999);
    step();

    prog(1'b1, 1'b1);
    wr_cnt(16'h0011);
    step();
    samp();
    chk("R10 decimal odd load", count, 16'h0011);
    step();
    samp();
    chk("R5 odd high first step one", count, 16'h0010);
    step();
    samp();
    chk("R10 decimal step two", count, 16'h0008);
    repeat (5) step();
    samp();
    chk("R5 odd low phase out", out, 0);
    chk("R10 decimal step three borrow", count, 16'h0008);
    step();

    prog(1'b0, 1'b1);
    wr_cnt(16'h0000);
    step();
    samp();
    chk("R9 decimal zero load", count, 16'h0000);
    step();
    samp();
    chk("R10 decimal 0000 minus 1", count, 16'h9999);
    step();

    // R9: full-range periods
    measure_zero(1'b0, 32768, "R9 binary zero");
    measure_zero(1'b1, 5000, "R9 decimal zero");

    // R2: configuring a running channel idles it
    prog(1'b0, 1'b0);
    wr_cnt(16'd7);
    step(); step(); step();
    prog(1'b1, 1'b0);
    samp();
    held = count;
    chk("R2 config raises out", out, 1);
    step(); step(); step();
    samp();
    chk("R2 config idles count", count, held);
    chk("R2 config idle out", out, 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule